// File: doc/BRIEF.md
# PC-relative literal load unit

This unit executes a single word load whose address is taken relative to the program counter. The instruction arrives in one of three encodings, selected by a mode input: a 32-bit fixed-width form, a 16-bit compact form and a 32-bit compact form. The unit decodes the fields and adds the read bias of the program counter to the supplied instruction address. It clears the two low bits of that value to get the base, then adds or subtracts a zero-extended immediate to form the effective address.

One 32-bit read goes out on a valid/ready request channel, and the response comes back on a valid/ready data channel. The returned word is written to a general register. If the destination is register 15, the word instead redirects the program counter as an interworking branch. Encodings that do not match, that belong to the unprivileged-load neighbour, or that are unpredictable are reported on single-cycle flag outputs. For these the unit issues no memory access.

An instruction is accepted when `issue_valid_i` is high while `issue_ready_o` is high. Every accepted instruction whose condition passes produces exactly one result pulse. The unit is ready again on the cycle after that pulse.

Top module: `lit_load_unit`

## Requirements
- R1: After reset, `issue_ready_o` is 1, and `rd_req_o` and all result outputs (`wr_en_o`, `br_valid_o`, `undef_o`, `unpred_o`, `alt_o`) are 0.
- R2: With `enc_i`=0 (fixed form), the instruction matches only when bits[27:25]=010, bit22=0, bit20=1, bits[19:16]=1111 and bits[31:28]≠1111. The destination is bits[15:12], the offset is bits[11:0] zero-extended, bit23=1 adds it and bit23=0 subtracts it, and the PC value is the instruction address + 8. A non-matching word, or `enc_i`=3, gives one `undef_o` pulse and no read.
- R3: In the fixed form, bit24=0 with bit21=1 gives one `alt_o` pulse and no read. Bit24 equal to bit21 (a writeback request) gives one `unpred_o` pulse and no read.
- R4: With `enc_i`=1 (16-bit form), only bits[15:0] are used. The form matches when bits[15:11]=01001. The destination is bits[10:8] (0 to 7), the offset is bits[7:0]×4 and always added, and the PC value is the instruction address + 4. A mismatch gives `undef_o`.
- R5: With `enc_i`=2 (32-bit compact form), the form matches when bits[31:24]=11111000, bits[22:20]=101 and bits[19:16]=1111. Bit23 selects add or subtract, the destination is bits[15:12], the offset is bits[11:0] zero-extended, and the PC value is the instruction address + 4.
- R6: Exactly one read is issued, at address (PC value with bits[1:0] cleared) ± offset. `rd_req_o` and `rd_addr_o` stay stable until `rd_gnt_i` is seen.
- R7: When the destination is not 15, the response word appears on `wr_data_o` with `wr_idx_o` during a single `wr_en_o` pulse, one cycle after the response handshake.
- R8: When the destination is 15 and the address bits[1:0]=00, the response gives a single `br_valid_o` pulse with `br_pc_o` = word with bit0 cleared and `br_compact_o` = word bit0. No register write occurs.
- R9: When the destination is 15 and the address bits[1:0]≠00, one `unpred_o` pulse is given and no read is issued.
- R10: In the 32-bit compact form, destination 15 with `in_blk_i`=1 and `last_in_blk_i`=0 gives `unpred_o` and no read. With `last_in_blk_i`=1 the load proceeds.
- R11: When `cond_pass_i`=0, an issued instruction has no effect: no read, no result pulse, and the unit stays ready.
- R12: At most one result output is high in any cycle, and `issue_ready_o` is 1 in the cycle after any result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Instruction present |
| issue_ready_o | output | 1 | Unit idle, instruction accepted |
| instr_i | input | 32 | Instruction word (16-bit form in bits[15:0]) |
| enc_i | input | 2 | 0 fixed, 1 16-bit compact, 2 32-bit compact, 3 reserved |
| inst_addr_i | input | AW | Address of the instruction |
| cond_pass_i | input | 1 | Condition passed |
| in_blk_i | input | 1 | Instruction lies inside a conditional block |
| last_in_blk_i | input | 1 | Instruction is last in its conditional block |
| rd_req_o | output | 1 | Read request valid |
| rd_addr_o | output | AW | Read address |
| rd_gnt_i | input | 1 | Read request ready |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | DW | Read data |
| rd_rsp_ready_o | output | 1 | Read data ready |
| wr_en_o | output | 1 | Register write pulse |
| wr_idx_o | output | RW | Register index |
| wr_data_o | output | DW | Register write data |
| br_valid_o | output | 1 | PC redirect pulse |
| br_pc_o | output | DW | New PC, bit0 cleared |
| br_compact_o | output | 1 | New encoding state from word bit0 |
| undef_o | output | 1 | Undefined encoding pulse |
| unpred_o | output | 1 | Unpredictable case pulse |
| alt_o | output | 1 | Encoding belongs to the unprivileged load |

## Verification
The assertions check on every cycle that a pending read keeps its request and address until granted, that result pulses never overlap, and that the unit is ready right after any pulse. They also check that a failed condition leaves the unit idle and that a branch only follows an aligned address. Only the bench's scenarios can show that field extraction, offset scaling, sign and PC bias produce the right address for each encoding. The same holds for choosing between register write and branch, for the bit0 state split, and for the priority among the undefined, neighbour-encoding and unpredictable outcomes.

// File: rtl/lit_load_pkg.sv
package lit_load_pkg;
  typedef enum logic [1:0] {ENC_FIXED = 2'd0, ENC_C16 = 2'd1, ENC_C32 = 2'd2, ENC_RSVD = 2'd3} enc_e;
  typedef enum logic [1:0] {RES_LOAD, RES_UNDEF, RES_ALT, RES_UNPRED} res_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_FIN} st_e;
  localparam int unsigned IMM_W  = 12;
  localparam int unsigned BIAS_W = 4;

  typedef struct packed {
    logic              match;
    logic              alt;
    logic              wb_bad;
    logic              blk_bad;
    logic              add;
    logic [3:0]        rt;
    logic [IMM_W-1:0]  imm;
    logic [BIAS_W-1:0] bias;
  } dec_t;
endpackage

// File: rtl/lit_decode.sv
module lit_decode
  import lit_load_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [1:0]  enc_i,
  input  logic        in_blk_i,
  input  logic        last_in_blk_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (enc_i)
      ENC_FIXED: begin
        dec_o.match  = (instr_i[31:28] != 4'hF) && (instr_i[27:25] == 3'b010) &&
                       !instr_i[22] && instr_i[20] && (instr_i[19:16] == 4'hF);
        dec_o.alt    = !instr_i[24] && instr_i[21];
        dec_o.wb_bad = (instr_i[24] == instr_i[21]);  // P=0,W=0 or P=1,W=1
        dec_o.add    = instr_i[23];
        dec_o.rt     = instr_i[15:12];
        dec_o.imm    = instr_i[11:0];
        dec_o.bias   = 4'd8;
      end
      ENC_C16: begin
        dec_o.match = (instr_i[15:11] == 5'b01001);
        dec_o.add   = 1'b1;
        dec_o.rt    = {1'b0, instr_i[10:8]};
        dec_o.imm   = {2'b00, instr_i[7:0], 2'b00};
        dec_o.bias  = 4'd4;
      end
      ENC_C32: begin
        dec_o.match   = (instr_i[31:24] == 8'hF8) && (instr_i[22:20] == 3'b101) &&
                        (instr_i[19:16] == 4'hF);
        dec_o.add     = instr_i[23];
        dec_o.rt      = instr_i[15:12];
        dec_o.imm     = instr_i[11:0];
        dec_o.bias    = 4'd4;
        dec_o.blk_bad = (instr_i[15:12] == 4'hF) && in_blk_i && !last_in_blk_i;
      end
      default: dec_o.match = 1'b0;
    endcase
  end
endmodule

// File: rtl/lit_agen.sv
module lit_agen
  import lit_load_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]     inst_addr_i,
  input  logic [BIAS_W-1:0] bias_i,
  input  logic              add_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [AW-1:0]     addr_o
);
  logic [AW-1:0] pc_rd, base, off;

  always_comb begin
    pc_rd  = inst_addr_i + {{(AW-BIAS_W){1'b0}}, bias_i};
    base   = {pc_rd[AW-1:2], 2'b00};
    off    = {{(AW-IMM_W){1'b0}}, imm_i};
    addr_o = add_i ? (base + off) : (base - off);
  end
endmodule

// File: rtl/lit_load_unit.sv
module lit_load_unit
  import lit_load_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_valid_i,
  output logic          issue_ready_o,
  input  logic [31:0]   instr_i,
  input  logic [1:0]    enc_i,
  input  logic [AW-1:0] inst_addr_i,
  input  logic          cond_pass_i,
  input  logic          in_blk_i,
  input  logic          last_in_blk_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_gnt_i,
  input  logic          rd_rsp_valid_i,
  input  logic [DW-1:0] rd_rsp_data_i,
  output logic          rd_rsp_ready_o,
  output logic          wr_en_o,
  output logic [RW-1:0] wr_idx_o,
  output logic [DW-1:0] wr_data_o,
  output logic          br_valid_o,
  output logic [DW-1:0] br_pc_o,
  output logic          br_compact_o,
  output logic          undef_o,
  output logic          unpred_o,
  output logic          alt_o
);
  localparam logic [RW-1:0] PC_IDX = RW'((1 << RW) - 1);

  dec_t          dec;
  logic [AW-1:0] ea;
  st_e           state_q;
  res_e          res_q, res_d;
  logic [RW-1:0] rt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          issue_fire, rt_pc, fin, load_fin, is_pc;

  lit_decode u_dec (
    .instr_i      (instr_i),
    .enc_i        (enc_i),
    .in_blk_i     (in_blk_i),
    .last_in_blk_i(last_in_blk_i),
    .dec_o        (dec)
  );

  lit_agen #(.AW(AW)) u_agen (
    .inst_addr_i(inst_addr_i),
    .bias_i     (dec.bias),
    .add_i      (dec.add),
    .imm_i      (dec.imm),
    .addr_o     (ea)
  );

  assign issue_fire = issue_valid_i && (state_q == ST_IDLE) && cond_pass_i;
  assign rt_pc      = (RW'(dec.rt) == PC_IDX);

  // priority: undefined, neighbour encoding, unpredictable, load
  always_comb begin
    if (!dec.match)                                         res_d = RES_UNDEF;
    else if (enc_i == ENC_FIXED && dec.alt)                 res_d = RES_ALT;
    else if ((enc_i == ENC_FIXED && dec.wb_bad) || dec.blk_bad ||
             (rt_pc && ea[1:0] != 2'b00))                   res_d = RES_UNPRED;
    else                                                    res_d = RES_LOAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_LOAD;
      rt_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (issue_fire) begin
          res_q   <= res_d;
          rt_q    <= RW'(dec.rt);
          addr_q  <= ea;
          state_q <= (res_d == RES_LOAD) ? ST_REQ : ST_FIN;
        end
        ST_REQ: if (rd_gnt_i) state_q <= ST_RSP;
        ST_RSP: if (rd_rsp_valid_i) begin
          data_q  <= rd_rsp_data_i;
          state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign issue_ready_o  = (state_q == ST_IDLE);
  assign rd_req_o       = (state_q == ST_REQ);
  assign rd_addr_o      = addr_q;
  assign rd_rsp_ready_o = (state_q == ST_RSP);

  assign fin      = (state_q == ST_FIN);
  assign load_fin = fin && (res_q == RES_LOAD);
  assign is_pc    = (rt_q == PC_IDX);

  assign wr_en_o      = load_fin && !is_pc;
  assign wr_idx_o     = rt_q;
  assign wr_data_o    = data_q;
  assign br_valid_o   = load_fin && is_pc;
  assign br_pc_o      = {data_q[DW-1:1], 1'b0};
  assign br_compact_o = data_q[0];
  assign undef_o      = fin && (res_q == RES_UNDEF);
  assign unpred_o     = fin && (res_q == RES_UNPRED);
  assign alt_o        = fin && (res_q == RES_ALT);

  a_r6_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o));

  a_r12_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, br_valid_o, undef_o, unpred_o, alt_o}));

  a_r12_ready_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || br_valid_o || undef_o || unpred_o || alt_o) |=> issue_ready_o);

  a_r8_branch_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_o |-> rd_addr_o[1:0] == 2'b00);

  a_r11_cond_fail_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && issue_ready_o && !cond_pass_i |=> issue_ready_o && !rd_req_o);
endmodule

// File: tb/lit_load_unit_bench.sv
`timescale 1ns/1ps
module lit_load_unit_bench;
  localparam int AW = 32, DW = 32, RW = 4;
  localparam int K_WR = 0, K_BR = 1, K_UNDEF = 2, K_UNPRED = 3, K_ALT = 4, K_NONE = 5;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic issue_valid = 0, cond_pass = 1, in_blk = 0, last_blk = 0;
  logic [31:0] instr = 0;
  logic [1:0] enc = 0;
  logic [AW-1:0] iaddr = 0;
  logic gnt = 0, rv = 0;
  logic [DW-1:0] rdata = 0;
  logic issue_ready_o, rd_req_o, rd_rsp_ready_o, wr_en_o, br_valid_o, br_compact_o;
  logic undef_o, unpred_o, alt_o;
  logic [AW-1:0] rd_addr_o;
  logic [RW-1:0] wr_idx_o;
  logic [DW-1:0] wr_data_o, br_pc_o;

  lit_load_unit #(.AW(AW), .DW(DW), .RW(RW)) u_lit_load_unit (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(issue_valid), .issue_ready_o(issue_ready_o),
    .instr_i(instr), .enc_i(enc), .inst_addr_i(iaddr), .cond_pass_i(cond_pass),
    .in_blk_i(in_blk), .last_in_blk_i(last_blk), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_gnt_i(gnt), .rd_rsp_valid_i(rv), .rd_rsp_data_i(rdata), .rd_rsp_ready_o(rd_rsp_ready_o),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .br_valid_o(br_valid_o),
    .br_pc_o(br_pc_o), .br_compact_o(br_compact_o), .undef_o(undef_o), .unpred_o(unpred_o),
    .alt_o(alt_o));

  int total = 0, bad = 0;
  bit finished = 0;

  int          exp_kind_q[$];
  logic [3:0]  exp_rt_q[$];
  logic [31:0] exp_data_q[$];
  string       exp_tag_q[$];
  logic [31:0] mem_addr_q[$];
  logic [31:0] mem_data_q[$];
  string       mem_tag_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_fixed(input logic [3:0] c, input bit p, input bit u,
                                          input bit w, input logic [3:0] rt, input logic [11:0] imm);
    return {c, 3'b010, p, u, 1'b0, w, 1'b1, 4'hF, rt, imm};
  endfunction
  function automatic logic [31:0] f_c16(input logic [2:0] rt, input logic [7:0] imm);
    return {16'h0, 5'b01001, rt, imm};
  endfunction
  function automatic logic [31:0] f_c32(input bit u, input logic [3:0] rt, input logic [11:0] imm);
    return {8'hF8, u, 3'b101, 4'hF, rt, imm};
  endfunction
  // R6 address model: aligned PC value +/- offset
  function automatic logic [31:0] f_ea(input logic [1:0] e, input logic [31:0] ia,
                                       input bit u, input logic [31:0] off);
    logic [31:0] pc;
    pc = ia + ((e == 2'd0) ? 32'd8 : 32'd4);
    pc[1:0] = 2'b00;
    return u ? pc + off : pc - off;
  endfunction

  task automatic run(input logic [31:0] ins, input logic [1:0] e, input logic [31:0] ia,
                     input bit cp, input bit ib, input bit lb, input logic [31:0] d,
                     input int kind, input logic [31:0] ea, input logic [3:0] rt, input string tag);
    @(negedge clk);
    while (!issue_ready_o) @(negedge clk);
    if (kind == K_WR || kind == K_BR) begin
      mem_addr_q.push_back(ea); mem_data_q.push_back(d); mem_tag_q.push_back(tag);
    end
    if (kind != K_NONE) begin
      exp_kind_q.push_back(kind); exp_rt_q.push_back(rt);
      exp_data_q.push_back(d); exp_tag_q.push_back(tag);
    end
    instr = ins; enc = e; iaddr = ia; cond_pass = cp; in_blk = ib; last_blk = lb;
    issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
    if (kind == K_NONE)
      chk(issue_ready_o && !rd_req_o, tag, "ignored instr left unit busy",
          {30'd0, issue_ready_o, rd_req_o}, 32'h2);
    while (exp_kind_q.size() != 0) @(negedge clk);
  endtask

  // memory responder
  initial begin : mem_model
    int dly = 0;
    logic [31:0] a;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && rd_req_o) begin
        a = rd_addr_o;
        if (mem_addr_q.size() == 0) chk(0, "R6", "unexpected read", a, 32'h0);
        else begin
          t = mem_tag_q.pop_front();
          chk(a == mem_addr_q[0], t, "read address", a, mem_addr_q[0]);
          void'(mem_addr_q.pop_front());
        end
        for (int i = 0; i < dly; i++) begin
          @(negedge clk);
          chk(rd_req_o && rd_addr_o == a, "R6", "request not held", rd_addr_o, a);
        end
        gnt = 1; @(negedge clk); gnt = 0;
        for (int i = 0; i < dly; i++) @(negedge clk);
        rdata = (mem_data_q.size() != 0) ? mem_data_q.pop_front() : 32'hDEAD_BEEF;
        rv = 1; @(negedge clk); rv = 0;
        dly = (dly + 1) % 3;
      end
    end
  end

  // result monitor
  initial begin : monitor
    bit prev = 0;
    int got, ek;
    logic [3:0] ert;
    logic [31:0] ed;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev) chk(issue_ready_o, "R12", "not ready after result", {31'd0, issue_ready_o}, 32'd1);
        if (wr_en_o | br_valid_o | undef_o | unpred_o | alt_o) begin
          chk($countones({wr_en_o, br_valid_o, undef_o, unpred_o, alt_o}) == 1, "R12",
              "overlapping results", {27'd0, wr_en_o, br_valid_o, undef_o, unpred_o, alt_o}, 32'd0);
          got = wr_en_o ? K_WR : br_valid_o ? K_BR : undef_o ? K_UNDEF : unpred_o ? K_UNPRED : K_ALT;
          if (exp_kind_q.size() == 0) chk(0, "R11", "unexpected result", got, K_NONE);
          else begin
            ek = exp_kind_q.pop_front(); ert = exp_rt_q.pop_front();
            ed = exp_data_q.pop_front(); t = exp_tag_q.pop_front();
            chk(got == ek, t, "result kind", got, ek);
            if (got == ek && ek == K_WR) begin
              chk(wr_idx_o == ert, t, "write index", {28'd0, wr_idx_o}, {28'd0, ert});
              chk(wr_data_o == ed, t, "write data", wr_data_o, ed);
            end
            if (got == ek && ek == K_BR) begin
              chk(br_pc_o == {ed[31:1], 1'b0}, t, "branch pc", br_pc_o, {ed[31:1], 1'b0});
              chk(br_compact_o == ed[0], t, "branch state", {31'd0, br_compact_o}, {31'd0, ed[0]});
            end
          end
          prev = 1;
        end else prev = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(issue_ready_o && !rd_req_o && !(wr_en_o | br_valid_o | undef_o | unpred_o | alt_o),
        "R1", "reset state", {29'd0, issue_ready_o, rd_req_o, wr_en_o}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    chk(issue_ready_o && !rd_req_o, "R1", "idle after reset", {30'd0, issue_ready_o, rd_req_o}, 32'h2);

    // R2 fixed form, add and subtract
    run(f_fixed(4'hE, 1, 1, 0, 4'd3, 12'h123), 2'd0, 32'h1000, 1, 0, 0, 32'hCAFE_0001,
        K_WR, f_ea(2'd0, 32'h1000, 1, 32'h123), 4'd3, "R2 fixed add");
    run(f_fixed(4'h0, 1, 0, 0, 4'd5, 12'hFFF), 2'd0, 32'h2002, 1, 0, 0, 32'h1234_5678,
        K_WR, f_ea(2'd0, 32'h2002, 0, 32'hFFF), 4'd5, "R2 R6 fixed sub max");
    run(f_fixed(4'hF, 1, 1, 0, 4'd1, 12'h0), 2'd0, 32'h100, 1, 0, 0, 0, K_UNDEF, 0, 0, "R2 cond 1111");
    run(f_fixed(4'hE, 1, 1, 0, 4'd1, 12'h0) | 32'h0040_0000, 2'd0, 32'h100, 1, 0, 0, 0,
        K_UNDEF, 0, 0, "R2 bit22 set");
    run(f_c16(3'd1, 8'h1), 2'd3, 32'h100, 1, 0, 0, 0, K_UNDEF, 0, 0, "R2 reserved enc");
    // R3
    run(f_fixed(4'hE, 0, 1, 1, 4'd2, 12'h8), 2'd0, 32'h100, 1, 0, 0, 0, K_ALT, 0, 0, "R3 P0 W1");
    run(f_fixed(4'hE, 1, 1, 1, 4'd2, 12'h8), 2'd0, 32'h100, 1, 0, 0, 0, K_UNPRED, 0, 0, "R3 P1 W1");
    run(f_fixed(4'hE, 0, 1, 0, 4'd2, 12'h8), 2'd0, 32'h100, 1, 0, 0, 0, K_UNPRED, 0, 0, "R3 P0 W0");
    // R4
    run(f_c16(3'd7, 8'hFF), 2'd1, 32'h3002, 1, 0, 0, 32'hA5A5_5A5A,
        K_WR, f_ea(2'd1, 32'h3002, 1, 32'h3FC), 4'd7, "R4 c16 max");
    run(f_c16(3'd0, 8'h00) | 32'hFFFF_0000, 2'd1, 32'h40, 1, 0, 0, 32'h0000_0011,
        K_WR, f_ea(2'd1, 32'h40, 1, 32'h0), 4'd0, "R4 c16 zero upper ignored");
    run(32'h0000_5100, 2'd1, 32'h40, 1, 0, 0, 0, K_UNDEF, 0, 0, "R4 c16 mismatch");
    // R5
    run(f_c32(0, 4'd12, 12'h7FF), 2'd2, 32'h5000, 1, 0, 0, 32'h0BAD_F00D,
        K_WR, f_ea(2'd2, 32'h5000, 0, 32'h7FF), 4'd12, "R5 c32 sub");
    run(f_c32(1, 4'd4, 12'hFFF), 2'd2, 32'h5FFE, 1, 0, 0, 32'h7777_0000,
        K_WR, f_ea(2'd2, 32'h5FFE, 1, 32'hFFF), 4'd4, "R5 c32 add max");
    run(f_c32(1, 4'd4, 12'h0) & 32'hFFBF_FFFF, 2'd2, 32'h100, 1, 0, 0, 0, K_UNDEF, 0, 0, "R5 c32 mismatch");
    // R8
    run(f_c32(1, 4'd15, 12'h4), 2'd2, 32'h6000, 1, 0, 0, 32'h0000_8001,
        K_BR, f_ea(2'd2, 32'h6000, 1, 32'h4), 4'd15, "R8 branch compact");
    run(f_fixed(4'hE, 1, 1, 0, 4'd15, 12'h10), 2'd0, 32'h7000, 1, 0, 0, 32'h9000_0004,
        K_BR, f_ea(2'd0, 32'h7000, 1, 32'h10), 4'd15, "R8 branch fixed");
    // R9
    run(f_fixed(4'hE, 1, 1, 0, 4'd15, 12'h1), 2'd0, 32'h7000, 1, 0, 0, 0, K_UNPRED, 0, 0, "R9 misaligned pc load");
    run(f_c32(0, 4'd15, 12'h2), 2'd2, 32'h7000, 1, 0, 0, 0, K_UNPRED, 0, 0, "R9 c32 misaligned");
    // R10
    run(f_c32(1, 4'd15, 12'h0), 2'd2, 32'h8000, 1, 1, 0, 0, K_UNPRED, 0, 0, "R10 in block not last");
    run(f_c32(1, 4'd15, 12'h0), 2'd2, 32'h8000, 1, 1, 1, 32'h0000_2000,
        K_BR, f_ea(2'd2, 32'h8000, 1, 32'h0), 4'd15, "R10 last in block");
    run(f_c32(1, 4'd14, 12'h0), 2'd2, 32'h8000, 1, 1, 0, 32'h0000_3333,
        K_WR, f_ea(2'd2, 32'h8000, 1, 32'h0), 4'd14, "R10 non pc in block");
    // R11
    run(f_fixed(4'hE, 1, 1, 0, 4'd6, 12'h20), 2'd0, 32'h900, 0, 0, 0, 0, K_NONE, 0, 0, "R11 cond fail fixed");
    run(32'h0000_5100, 2'd1, 32'h900, 0, 0, 0, 0, K_NONE, 0, 0, "R11 cond fail undef pattern");
    run(f_c16(3'd2, 8'h3), 2'd1, 32'h904, 1, 0, 0, 32'h0000_0042,
        K_WR, f_ea(2'd1, 32'h904, 1, 32'hC), 4'd2, "R11 R7 load after cond fail");

    repeat (4) @(negedge clk);
    chk(exp_kind_q.size() == 0 && mem_addr_q.size() == 0, "R12", "pending expectations",
        exp_kind_q.size() + mem_addr_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule